// File: doc/BRIEF.md
# Port Edge Change-Detect Interrupt Controller

This block watches a bank of digital input lines, grouped into 8-bit ports, and raises a level interrupt when one of them changes in a direction that software has selected. Each port carries two mask registers, one for rising and one for falling transitions. Any enabled transition on any port feeds one shared edge event. That event sets a pending flag and records whether it was rising or falling.

A global control register gates the whole path. It has separate enables for edge capture, overflow capture, the interrupt pin, and each edge polarity. A second event that arrives while the pending flag is still set raises an overflow flag. Software reads the status register, then acknowledges the flags by writing ones to a clear register. The usual arming sequence is to clear the flags first and then write the control register. Writing zero to control stops all capture.

The register port is a plain synchronous interface: an address, write data and a write strobe, with read data returned combinationally. The inputs are asynchronous to the clock and are synchronised inside the block.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, the control register and every mask register read 0x00, the status register reads 0x00, and `irq` is low.
- R2: Register map:
  - Clear register at 0x01 (reads 0x00).
  - Status register at 0x02 (read only).
  - Control register at 0x03.
  - Rising mask of port p at 0x42+0x10*p; falling mask of port p at 0x43+0x10*p.
  - Control and mask registers read back the last value written. Control bits above bit 4 read as 0.
- R3: Control bit0 (edge capture) and bit3 (rising polarity) both 1, with a 0-to-1 change on a channel whose rising-mask bit is 1: status bit0 (pending) and bit3 (rising seen) become 1 on the third rising clock edge after the input change. They are not yet set after the second.
- R4: Control bit0 and bit4 (falling polarity) both 1, with a 1-to-0 change on a channel whose falling-mask bit is 1: status bit0 and bit4 (falling seen) become 1.
- R5: A transition produces no event when either the channel's mask bit for that direction is 0 or the control polarity bit for that direction is 0.
- R6: An event that occurs while status bit0 is already 1 sets status bit1 (overflow), provided control bit1 is 1. With control bit1 at 0, the overflow flag stays 0.
- R7: Writing to the clear register 0x01:
  - Bit3 = 1 clears status bits 0, 3 and 4.
  - Bit2 = 1 clears status bit1.
  - Zero bits leave the flags unchanged.
- R8: `irq` and status bit2 are both 1 exactly when control bit2 (interrupt enable) is 1 and status bit0 or bit1 is 1.
- R9: With control written to 0x00, no input transition sets any flag. Flags captured earlier are held.
- R10: Bit n of port p's masks governs input line `din[p*8+n]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | NPORTS*8 | Asynchronous digital input lines |
| addr | input | AW | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults: four ports (32 channels) and an 8-bit address. This places every port's mask pair in the address map and lets a random line on any port be checked against the mask bit that governs it.

Random mask values, control values and input patterns are mixed with directed cases:
- the exact capture latency;
- overflow with the overflow enable on and off;
- a clear write with zero bits;
- capture blocked by writing zero to control.

A model in the bench follows the flags from the requirements alone.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int NPORTS = 4,
  parameter int AW     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORTS*8-1:0]   din,
  input  logic [AW-1:0]         addr,
  input  logic                  wr_en,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  output logic                  irq
);
  localparam int NCH = NPORTS * 8;
  localparam logic [AW-1:0] A_CLR  = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);
  localparam logic [AW-1:0] A_CTRL = AW'(3);

  logic [NCH-1:0] sy1, sy2, sy3;
  logic [NCH-1:0] rmask, fmask;
  logic [4:0]     ctrl;
  logic           pend, ovf, rseen, fseen;
  logic           rise_hit, fall_hit, evt, clr_e, clr_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      sy3 <= '0;
    end else begin
      sy1 <= din;
      sy2 <= sy1;
      sy3 <= sy2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= '0;
    else if (wr_en && addr == A_CTRL) ctrl <= wdata[4:0];
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam logic [AW-1:0] A_RISE = AW'(8'h42 + 16 * p);
    localparam logic [AW-1:0] A_FALL = AW'(8'h43 + 16 * p);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rmask[p*8 +: 8] <= '0;
        fmask[p*8 +: 8] <= '0;
      end else if (wr_en) begin
        if (addr == A_RISE) rmask[p*8 +: 8] <= wdata;
        if (addr == A_FALL) fmask[p*8 +: 8] <= wdata;
      end
    end
  end

  assign rise_hit = ctrl[3] & |(sy2 & ~sy3 & rmask);
  assign fall_hit = ctrl[4] & |(~sy2 & sy3 & fmask);
  assign evt      = ctrl[0] & (rise_hit | fall_hit);
  assign clr_e    = wr_en & (addr == A_CLR) & wdata[3];
  assign clr_o    = wr_en & (addr == A_CLR) & wdata[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      ovf   <= 1'b0;
      rseen <= 1'b0;
      fseen <= 1'b0;
    end else begin
      pend  <= evt | (pend & ~clr_e);
      rseen <= (evt & rise_hit) | (rseen & ~clr_e);
      fseen <= (evt & fall_hit) | (fseen & ~clr_e);
      ovf   <= (evt & pend & ctrl[1]) | (ovf & ~clr_o);
    end
  end

  assign irq = ctrl[2] & (pend | ovf);

  always_comb begin
    rdata = 8'h00;
    if (addr == A_STAT) rdata = {3'b000, fseen, rseen, irq, ovf, pend};
    if (addr == A_CTRL) rdata = {3'b000, ctrl};
    for (int p = 0; p < NPORTS; p++) begin
      if (addr == AW'(8'h42 + 16 * p)) rdata = rmask[p*8 +: 8];
      if (addr == AW'(8'h43 + 16 * p)) rdata = fmask[p*8 +: 8];
    end
  end
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    ctrl,
  input logic          pend,
  input logic          ovf,
  input logic          rseen,
  input logic          fseen,
  input logic          irq,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [7:0]    wdata
);
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[2] |-> !irq);

  p_ovf_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> ($past(pend) && $past(ctrl[1])));

  p_pend_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(ctrl[0]));

  p_seen_with_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rseen || fseen) |-> pend);

  p_zero_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(1) && wdata[3:2] == 2'b00 && pend && ovf) |=> (pend && ovf));
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .pend(pend), .ovf(ovf),
  .rseen(rseen), .fseen(fseen), .irq(irq), .wr_en(wr_en),
  .addr(addr), .wdata(wdata)
);

// File: tb/edge_irq_ctrl_bench.sv
module edge_irq_ctrl_bench;
  localparam int NP  = 4;
  localparam int NCH = NP * 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] din = '0;
  logic [7:0]     addr = 8'h00;
  logic           wr_en = 1'b0;
  logic [7:0]     wdata = 8'h00;
  logic [7:0]     rdata;
  logic           irq;

  int total = 0;
  int bad = 0;

  logic [NCH-1:0] m_rise = '0, m_fall = '0;
  logic [4:0]     m_ctrl = '0;
  logic           m_pend = 0, m_ovf = 0, m_rs = 0, m_fs = 0;

  edge_irq_ctrl #(.NPORTS(NP), .AW(8)) u_edge_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .din(din), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 8'h03) m_ctrl = d[4:0];
    if (a == 8'h01) begin
      if (d[3]) begin m_pend = 0; m_rs = 0; m_fs = 0; end
      if (d[2]) m_ovf = 0;
    end
    for (int p = 0; p < NP; p++) begin
      if (a == 8'(8'h42 + 16 * p)) m_rise[p*8 +: 8] = d;
      if (a == 8'(8'h43 + 16 * p)) m_fall[p*8 +: 8] = d;
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #2;
    d = rdata;
  endtask

  function automatic logic exp_irq();
    return m_ctrl[2] & (m_pend | m_ovf);
  endfunction

  function automatic logic [7:0] exp_status();
    return {3'b000, m_fs, m_rs, exp_irq(), m_ovf, m_pend};
  endfunction

  function automatic logic [1:0] exp_hits(input logic [NCH-1:0] o, input logic [NCH-1:0] n);
    logic r, f;
    r = m_ctrl[3] & |(~o & n & m_rise);
    f = m_ctrl[4] & |(o & ~n & m_fall);
    return {f, r};
  endfunction

  task automatic step(input logic [NCH-1:0] n);
    logic [1:0] h;
    logic [NCH-1:0] o;
    @(negedge clk);
    o = din;
    din = n;
    repeat (4) @(negedge clk);
    h = exp_hits(o, n);
    if (m_ctrl[0] && (h != 2'b00)) begin
      if (m_pend && m_ctrl[1]) m_ovf = 1;
      m_pend = 1;
      if (h[0]) m_rs = 1;
      if (h[1]) m_fs = 1;
    end
  endtask

  task automatic chk_status(input string tag);
    logic [7:0] d;
    rd(8'h02, d);
    chk({tag, " status"}, d, exp_status());
    chk({tag, " irq"}, irq, exp_irq());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd7531));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(8'h03, d); chk("R1 ctrl", d, 8'h00);
    for (int p = 0; p < NP; p++) begin
      rd(8'(8'h42 + 16 * p), d); chk("R1 rise mask", d, 8'h00);
      rd(8'(8'h43 + 16 * p), d); chk("R1 fall mask", d, 8'h00);
    end
    rd(8'h02, d); chk("R1 status", d, 8'h00);
    chk("R1 irq", irq, 1'b0);

    // R2, R10: register map and readback
    wr(8'h42, 8'h01); wr(8'h63, 8'h80); wr(8'h72, 8'h20);
    rd(8'h42, d); chk("R2 port0 rise", d, 8'h01);
    rd(8'h63, d); chk("R2 port2 fall", d, 8'h80);
    rd(8'h72, d); chk("R2 port3 rise", d, 8'h20);
    wr(8'h03, 8'hFF); rd(8'h03, d); chk("R2 ctrl upper bits", d, 8'h1F);
    rd(8'h01, d); chk("R2 clear reads zero", d, 8'h00);

    // Arm: clear first, then control
    wr(8'h01, 8'h0C); wr(8'h03, 8'h1F);

    // R5: rising on port2 bit7 has no rising mask
    step(32'h0080_0000);
    chk_status("R5 unmasked rise");

    // R3: exact latency on din[0]
    @(negedge clk); din[0] = 1'b1; addr = 8'h02;
    @(negedge clk); @(negedge clk); #2;
    chk("R3 not before third edge", rdata[0], 1'b0);
    @(negedge clk); #2;
    chk("R3 pending at third edge", rdata, 8'h0D);
    m_pend = 1; m_rs = 1;
    chk_status("R3 R8 after rise");

    // R4, R6: falling on port2 bit7 while pending -> overflow
    step(32'h0000_0001);
    chk_status("R4 R6 fall with overflow");

    // R7: zero clear bits have no effect
    wr(8'h01, 8'hF3); chk_status("R7 zero bits");
    wr(8'h01, 8'h04); chk_status("R7 clear overflow only");
    wr(8'h01, 8'h08); chk_status("R7 clear edge flags");

    // R10: port3 bit5 -> din[29]
    step(32'h2000_0001); chk_status("R10 port3 bit5 rise");

    // R8: interrupt enable off masks irq
    wr(8'h03, 8'h1B); chk_status("R8 irq disabled");

    // R6: overflow enable off
    wr(8'h03, 8'h1D); step(32'h0000_0000); chk_status("R6 overflow disabled");

    // R9: control zero blocks capture, flags held
    wr(8'h03, 8'h00); step(32'hFFFF_FFFF); chk_status("R9 disabled");
    step(32'h0000_0000); chk_status("R9 disabled fall");

    // R5: polarity enable off
    wr(8'h01, 8'h0C); wr(8'h03, 8'h0F); wr(8'h43, 8'hFF);
    step(32'h0000_0001); step(32'h0000_0000); chk_status("R5 fall polarity off");

    // Random mix
    for (int i = 0; i < 80; i++) begin
      int p;
      p = $urandom_range(NP - 1);
      if ($urandom_range(1)) wr(8'(8'h42 + 16 * p), 8'($urandom));
      if ($urandom_range(1)) wr(8'(8'h43 + 16 * p), 8'($urandom));
      if ($urandom_range(3) == 0) wr(8'h03, 8'($urandom) | 8'h01);
      step($urandom);
      chk_status("R3 R4 R5 R6 R10 random");
      if ($urandom_range(2) == 0) begin
        wr(8'h01, 8'($urandom));
        chk_status("R7 random clear");
      end
      if ($urandom_range(4) == 0) begin
        rd(8'(8'h42 + 16 * p), d); chk("R2 random rise readback", d, m_rise[p*8 +: 8]);
        rd(8'(8'h43 + 16 * p), d); chk("R2 random fall readback", d, m_fall[p*8 +: 8]);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule